// File: doc/BRIEF.md
# Shared Video RAM Clock-Stretch Arbiter

A video fetcher and a CPU share one video RAM. Every scan line holds 171 memory access slots, grouped in threes. Two slots in each group go to the fetcher and one is left free for the CPU. The slot timing and the CPU clock come from unrelated oscillators, so no fixed number of wait states can place a CPU access on a free slot. This block runs on a fast system clock and watches two inputs: a slot strobe and the CPU half-cycle enable. When the CPU starts an access that touches the shared memory, the block withholds half-cycle enables until a free slot has begun. The CPU is therefore frozen for a whole number of clock transitions.

Only accesses that the video fetcher can also reach are held back. These are the four 16 KB segments that the fetcher reads, and the video chip's own I/O ports. Every other access runs with no alignment: ROM, other RAM segments, the sound and paging chip, and CPU refresh cycles. The block also reports which slot is current and who owns it, so that the neighbouring DRAM sequencer can steer the row and column cycle.

Top module: `vsa_arbiter`

## Requirements
- R1: `slot_index` is 0 after reset. It advances by one on each `slot_stb`, wraps from 170 to 0, and holds its value between strobes.
- R2: `slot_owner` is 0 (CPU) exactly when `slot_index` mod 3 equals 2.
- R3: Every other slot is a video slot. The bench counts video slots from 0 at the start of the line, where the video ordinal is `slot_index - slot_index/3`. Ordinals 0 to 15 report 1 (parameter block fetch). Ordinals 108 to 113 report 3 (refresh). All other ordinals report 2 (pixel fetch).
- R4: An access needs arbitration in two cases. The first is `mem_rq` high with `mem_rfsh` low and `mem_seg` in 0xFC to 0xFF. The second is `io_rq` high with `io_port[7:4]` equal to 0x8.
- R5: Any other access never stalls the CPU and never raises `cpu_grant`. Such accesses include other segments, refresh cycles to the video segments, and other ports. For these, `cpu_ce` equals `cpu_hc_en` throughout.
- R6: An arbitrated request is sampled on a cycle with `cpu_hc_en` high. Let S be the first strobe at or after that cycle whose new slot is CPU-owned. `cpu_ce` is then low on every enable cycle before S and passes the first enable cycle at or after S.
- R7: `cpu_ce` is never high in a cycle where `cpu_hc_en` is low, so a stretch removes whole half-cycles only.
- R8: `cpu_grant` rises in the cycle after the releasing enable. It stays high up to and including the cycle of the next `slot_stb`, and is low at all other times.
- R9: Once served, an access that keeps its request asserted gets every later half-cycle enable without a further stretch.
- R10: While `rst_n` is low, `cpu_grant` is 0, `slot_index` is 0 and `slot_owner` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | One-cycle pulse at the start of each RAM slot |
| cpu_hc_en | input | 1 | One-cycle pulse at each CPU clock transition |
| mem_rq | input | 1 | CPU memory cycle in progress |
| io_rq | input | 1 | CPU I/O cycle in progress |
| mem_rfsh | input | 1 | Current memory cycle is a CPU refresh |
| mem_seg | input | 8 | Physical 16 KB segment number of the access |
| io_port | input | 8 | I/O port address, low byte |
| cpu_ce | output | 1 | Gated half-cycle enable for the CPU |
| cpu_grant | output | 1 | CPU access owns the current free slot |
| slot_owner | output | 2 | 0 CPU, 1 parameter fetch, 2 pixel fetch, 3 refresh |
| slot_index | output | 8 | Current slot number within the line |

## Verification
Arbitrated accesses are started on enable cycles that drift across the 17-cycle slot and 51-cycle group pattern. The drift comes from idle gaps of varying length and from two enable spacings: a slow CPU whose half-cycle is longer than a third of a slot, and a faster one. The expected release comes from strobe and enable arithmetic alone. This tells apart a release that lands exactly on a free-slot start, one that follows it, and one that must skip a slot already in progress. Bypass accesses cover a segment just below the window, a refresh cycle to a video segment, and an out-of-range port, checking that address decoding alone decides stalling. Two idle lines sweep the slot index and the owner code across the wrap and the fetch and refresh boundaries.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

  typedef enum logic [1:0] {
    OWN_CPU     = 2'd0,
    OWN_PARAM   = 2'd1,
    OWN_PIXEL   = 2'd2,
    OWN_REFRESH = 2'd3
  } owner_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GRANT = 2'd2,
    ST_HOLD  = 2'd3
  } arb_st_e;

endpackage

// File: rtl/vsa_slot_timer.sv
module vsa_slot_timer
  import vsa_pkg::*;
#(
  parameter int SLOTS         = 171,
  parameter int GROUP         = 3,
  parameter int CPU_PHASE     = 2,
  parameter int PARAM_SLOTS   = 16,
  parameter int REFRESH_SLOTS = 6,
  parameter int IDX_W         = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_stb,
  output logic [IDX_W-1:0] slot_idx,
  output owner_e           owner,
  output logic             cpu_slot_start
);

  localparam int PH_W        = (GROUP > 2) ? $clog2(GROUP) : 1;
  localparam int VIDEO_SLOTS = SLOTS - SLOTS / GROUP;
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(SLOTS - 1);
  localparam logic [IDX_W-1:0] PARAM_LIM  = IDX_W'(PARAM_SLOTS);
  localparam logic [IDX_W-1:0] RFSH_FIRST = IDX_W'(VIDEO_SLOTS - REFRESH_SLOTS);
  localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(GROUP - 1);
  localparam logic [PH_W-1:0]  PH_CPU     = PH_W'(CPU_PHASE);

  logic [IDX_W-1:0] idx_q, idx_n;
  logic [PH_W-1:0]  ph_q, ph_n, ph_step;
  logic [IDX_W-1:0] vord_q, vord_n;
  logic             at_end;

  always_comb begin
    at_end  = (idx_q == LAST_IDX);
    ph_step = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    idx_n   = idx_q;
    ph_n    = ph_q;
    vord_n  = vord_q;
    if (at_end) begin
      idx_n  = '0;
      ph_n   = '0;
      vord_n = '0;
    end else begin
      idx_n = idx_q + 1'b1;
      ph_n  = ph_step;
      if (ph_q != PH_CPU) vord_n = vord_q + 1'b1;
    end
    cpu_slot_start = slot_stb && (ph_n == PH_CPU);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ph_q   <= '0;
      vord_q <= '0;
    end else if (slot_stb) begin
      idx_q  <= idx_n;
      ph_q   <= ph_n;
      vord_q <= vord_n;
    end
  end

  always_comb begin
    slot_idx = idx_q;
    if (ph_q == PH_CPU)          owner = OWN_CPU;
    else if (vord_q < PARAM_LIM)  owner = OWN_PARAM;
    else if (vord_q >= RFSH_FIRST) owner = OWN_REFRESH;
    else                          owner = OWN_PIXEL;
  end

endmodule

// File: rtl/vsa_region_decode.sv
module vsa_region_decode #(
  parameter int SEG_W          = 8,
  parameter int VRAM_SEG_FIRST = 252,
  parameter int VRAM_SEG_COUNT = 4,
  parameter int PORT_W         = 8,
  parameter int PORT_MATCH     = 'h80,
  parameter int PORT_MASK      = 'hF0
) (
  input  logic              mem_rq,
  input  logic              io_rq,
  input  logic              mem_rfsh,
  input  logic [SEG_W-1:0]  mem_seg,
  input  logic [PORT_W-1:0] io_port,
  output logic              need_arb
);

  localparam logic [SEG_W-1:0]  SEG_LO   = SEG_W'(VRAM_SEG_FIRST);
  localparam logic [SEG_W-1:0]  SEG_CNT  = SEG_W'(VRAM_SEG_COUNT);
  localparam logic [PORT_W-1:0] P_MATCH  = PORT_W'(PORT_MATCH);
  localparam logic [PORT_W-1:0] P_MASK   = PORT_W'(PORT_MASK);

  logic [SEG_W-1:0] seg_off;
  logic             seg_hit;
  logic             port_hit;

  always_comb begin
    seg_off  = mem_seg - SEG_LO;
    seg_hit  = (seg_off < SEG_CNT);
    port_hit = ((io_port & P_MASK) == P_MATCH);
    need_arb = (mem_rq && !mem_rfsh && seg_hit) || (io_rq && port_hit);
  end

endmodule

// File: rtl/vsa_stretch_fsm.sv
module vsa_stretch_fsm
  import vsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hc_en,
  input  logic need,
  input  logic cpu_start,
  input  logic slot_stb,
  output logic ce,
  output logic grant
);

  arb_st_e st_q, st_n;
  logic    armed_q, armed_n;
  logic    release_now;

  always_comb begin
    st_n        = st_q;
    armed_n     = 1'b0;
    ce          = hc_en;
    release_now = hc_en && (cpu_start || armed_q);
    case (st_q)
      ST_IDLE: begin
        if (hc_en && need) begin
          if (cpu_start) begin
            st_n = ST_GRANT;
          end else begin
            ce   = 1'b0;
            st_n = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!need) begin
          st_n = ST_IDLE;
        end else if (release_now) begin
          st_n = ST_GRANT;
        end else begin
          ce = 1'b0;
          if (cpu_start)     armed_n = 1'b1;
          else if (slot_stb) armed_n = 1'b0;
          else               armed_n = armed_q;
        end
      end
      ST_GRANT: begin
        if (slot_stb) st_n = need ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: begin
        if (!need) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    grant = (st_q == ST_GRANT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      armed_q <= armed_n;
    end
  end

endmodule

// File: rtl/vsa_arbiter.sv
module vsa_arbiter
  import vsa_pkg::*;
#(
  parameter int SLOTS_PER_LINE  = 171,
  parameter int SLOTS_PER_GROUP = 3,
  parameter int CPU_PHASE       = 2,
  parameter int PARAM_SLOTS     = 16,
  parameter int REFRESH_SLOTS   = 6,
  parameter int SEG_W           = 8,
  parameter int VRAM_SEG_FIRST  = 252,
  parameter int VRAM_SEG_COUNT  = 4,
  parameter int PORT_W          = 8,
  parameter int PORT_MATCH      = 'h80,
  parameter int PORT_MASK       = 'hF0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              slot_stb,
  input  logic                              cpu_hc_en,
  input  logic                              mem_rq,
  input  logic                              io_rq,
  input  logic                              mem_rfsh,
  input  logic [SEG_W-1:0]                  mem_seg,
  input  logic [PORT_W-1:0]                 io_port,
  output logic                              cpu_ce,
  output logic                              cpu_grant,
  output logic [1:0]                        slot_owner,
  output logic [$clog2(SLOTS_PER_LINE)-1:0] slot_index
);

  localparam int IDX_W = $clog2(SLOTS_PER_LINE);

  logic [1:0] rs_q;
  logic       rst_int_n;
  logic       need_arb;
  logic       cpu_start;
  owner_e     owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  vsa_slot_timer #(
    .SLOTS         (SLOTS_PER_LINE),
    .GROUP         (SLOTS_PER_GROUP),
    .CPU_PHASE     (CPU_PHASE),
    .PARAM_SLOTS   (PARAM_SLOTS),
    .REFRESH_SLOTS (REFRESH_SLOTS),
    .IDX_W         (IDX_W)
  ) timer_i (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .slot_stb       (slot_stb),
    .slot_idx       (slot_index),
    .owner          (owner),
    .cpu_slot_start (cpu_start)
  );

  vsa_region_decode #(
    .SEG_W          (SEG_W),
    .VRAM_SEG_FIRST (VRAM_SEG_FIRST),
    .VRAM_SEG_COUNT (VRAM_SEG_COUNT),
    .PORT_W         (PORT_W),
    .PORT_MATCH     (PORT_MATCH),
    .PORT_MASK      (PORT_MASK)
  ) decode_i (
    .mem_rq   (mem_rq),
    .io_rq    (io_rq),
    .mem_rfsh (mem_rfsh),
    .mem_seg  (mem_seg),
    .io_port  (io_port),
    .need_arb (need_arb)
  );

  vsa_stretch_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hc_en     (cpu_hc_en),
    .need      (need_arb),
    .cpu_start (cpu_start),
    .slot_stb  (slot_stb),
    .ce        (cpu_ce),
    .grant     (cpu_grant)
  );

  assign slot_owner = owner;

endmodule

// File: rtl/vsa_arbiter_chk.sv
module vsa_arbiter_chk #(
  parameter int SLOTS_PER_LINE = 171,
  parameter int IDX_W          = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_stb,
  input logic             cpu_hc_en,
  input logic             mem_rq,
  input logic             io_rq,
  input logic             mem_rfsh,
  input logic             cpu_ce,
  input logic             cpu_grant,
  input logic [1:0]       slot_owner,
  input logic [IDX_W-1:0] slot_index
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS_PER_LINE - 1);

  // R7
  ce_whole_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> cpu_hc_en);

  // R1
  index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && slot_index == LAST_IDX) |=> (slot_index == '0));

  // R1
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> $stable(slot_index));

  // R8
  grant_in_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant |-> (slot_owner == 2'd0));

  // R8
  grant_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_grant) |-> $past(cpu_ce));

  // R5
  bypass_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hc_en && !io_rq && (!mem_rq || mem_rfsh)) |-> cpu_ce);

endmodule

bind vsa_arbiter vsa_arbiter_chk #(
  .SLOTS_PER_LINE (SLOTS_PER_LINE),
  .IDX_W          ($clog2(SLOTS_PER_LINE))
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_stb   (slot_stb),
  .cpu_hc_en  (cpu_hc_en),
  .mem_rq     (mem_rq),
  .io_rq      (io_rq),
  .mem_rfsh   (mem_rfsh),
  .cpu_ce     (cpu_ce),
  .cpu_grant  (cpu_grant),
  .slot_owner (slot_owner),
  .slot_index (slot_index)
);

// File: tb/vsa_arbiter_tb_top.sv
module vsa_arbiter_tb_top;

  localparam int SP    = 17;
  localparam int SLOTS = 171;

  logic       clk;
  logic       rst_n;
  logic       slot_stb, cpu_hc_en, mem_rq, io_rq, mem_rfsh;
  logic [7:0] mem_seg, io_port;
  logic       cpu_ce, cpu_grant;
  logic [1:0] slot_owner;
  logic [7:0] slot_index;

  int   t;
  int   hp;
  int   errs;
  int   checks;
  bit   done;
  logic q_m, q_i, q_r;
  logic [7:0] q_seg, q_port;

  vsa_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .cpu_hc_en(cpu_hc_en),
    .mem_rq(mem_rq), .io_rq(io_rq), .mem_rfsh(mem_rfsh), .mem_seg(mem_seg),
    .io_port(io_port), .cpu_ce(cpu_ce), .cpu_grant(cpu_grant),
    .slot_owner(slot_owner), .slot_index(slot_index)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at t=%0d: actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  function automatic int exp_owner(input int idx);
    int ord;
    if (idx % 3 == 2) return 0;
    ord = idx - idx / 3;
    if (ord < 16) return 1;
    if (ord >= 108) return 3;
    return 2;
  endfunction

  task automatic step(input bit idle_chk);
    int idx;
    @(negedge clk);
    t++;
    slot_stb  = (t > 0) && (t % SP == 0);
    cpu_hc_en = (t % hp == 0);
    mem_rq = q_m; io_rq = q_i; mem_rfsh = q_r; mem_seg = q_seg; io_port = q_port;
    #5;
    idx = ((t > 0) ? (t - 1) / SP : 0) % SLOTS;
    chk(int'(slot_index) == idx, "R1 slot index", int'(slot_index), idx);
    chk(int'(slot_owner) == exp_owner(idx), (idx % 3 == 2) ? "R2 owner" : "R3 owner",
        int'(slot_owner), exp_owner(idx));
    chk(!(cpu_ce && !cpu_hc_en), "R7 ce without enable", int'(cpu_ce), 0);
    if (idle_chk) begin
      chk(cpu_ce == cpu_hc_en, "R5 idle ce", int'(cpu_ce), int'(cpu_hc_en));
      chk(cpu_grant == 1'b0, "R8 idle grant", int'(cpu_grant), 0);
    end
  endtask

  task automatic run_access(input bit m, input bit i, input bit r,
                            input logic [7:0] seg, input logic [7:0] port,
                            input bit arb);
    int tr, k, s, rel, snext, last;
    bit exp_ce, exp_g;
    while (((t + 1) % hp) != 0) step(1);
    q_m = m; q_i = i; q_r = r; q_seg = seg; q_port = port;
    step(0);
    tr = t;
    if (arb) begin
      k = (tr + SP - 1) / SP;
      if (k < 1) k = 1;
      while ((k % SLOTS) % 3 != 2) k++;
      s     = k * SP;
      rel   = ((s + hp - 1) / hp) * hp;
      snext = (rel / SP + 1) * SP;
    end else begin
      rel   = tr;
      snext = -1;
    end
    last = -1;
    forever begin
      exp_ce = (t % hp == 0) && (t >= rel);
      exp_g  = arb && (t > rel) && (t <= snext);
      if (arb) begin
        if (t > rel) chk(cpu_ce == exp_ce, "R9 served ce", int'(cpu_ce), int'(exp_ce));
        else         chk(cpu_ce == exp_ce, "R4 R6 stretch ce", int'(cpu_ce), int'(exp_ce));
        chk(cpu_grant == exp_g, "R8 grant", int'(cpu_grant), int'(exp_g));
      end else begin
        chk(cpu_ce == exp_ce, "R5 bypass ce", int'(cpu_ce), int'(exp_ce));
        chk(cpu_grant == 1'b0, "R5 bypass grant", int'(cpu_grant), 0);
      end
      if (last < 0 && (t % hp == 0) && t > rel) begin
        q_m = 1'b0; q_i = 1'b0; q_r = 1'b0;
        last = ((snext > t) ? snext : t) + 1;
      end
      if (last >= 0 && t >= last) break;
      step(0);
    end
  endtask

  initial begin
    errs = 0; checks = 0; done = 1'b0; t = -1; hp = 6;
    q_m = 0; q_i = 0; q_r = 0; q_seg = 8'h00; q_port = 8'h00;
    rst_n = 1'b0; slot_stb = 0; cpu_hc_en = 0; mem_rq = 0; io_rq = 0;
    mem_rfsh = 0; mem_seg = 0; io_port = 0;
    repeat (3) @(negedge clk);
    #5;
    // R10 reset state
    chk(cpu_grant == 1'b0, "R10 reset grant", int'(cpu_grant), 0);
    chk(slot_index == 8'd0, "R10 reset index", int'(slot_index), 0);
    chk(slot_owner == 2'd1, "R10 reset owner", int'(slot_owner), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // two idle lines: index wrap and owner classes (R1, R2, R3)
    repeat (2 * SLOTS * SP + 40) step(1);

    for (int sp_sel = 0; sp_sel < 2; sp_sel++) begin
      hp = (sp_sel == 0) ? 6 : 4;
      for (int n = 0; n < 24; n++) begin
        for (int g = 0; g < n % 7; g++) step(1);
        case (n % 4)
          0: run_access(1, 0, 0, 8'hFC + 8'((n / 4) % 4), 8'h00, 1);
          1: run_access(0, 1, 0, 8'h00, 8'h80 + 8'(n % 16), 1);
          2: run_access(1, 0, 0, 8'hFB - 8'(n), 8'h00, 0);
          default: begin
            if ((n / 4) % 2 == 0) run_access(1, 0, 1, 8'hFE, 8'h00, 0);
            else                  run_access(0, 1, 0, 8'h00, 8'hB0 + 8'(n), 0);
          end
        endcase
        repeat (3) step(1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule